// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block keeps the stack pointer of an 8-bit processor. The pointer starts at the top of internal data memory and moves toward lower addresses as data is pushed. Each cycle the core presents one stack operation code. The block then drives the data-memory byte addresses for that access on up to two address lanes and moves the pointer by the step the operation needs. A single data byte moves it by one. A return address, saved on a call or interrupt entry and restored on a return, moves it by two.

Software sees the pointer as two byte-wide I/O registers, a low byte and a high byte. Both can be read at any time and each can be written on its own. If a push takes the pointer into the reserved region below the floor address, a sticky error flag is raised. The flag stays set until software moves the pointer with an I/O write.

Top module: `stack_pointer_unit`

## Requirements
- R1: After reset the pointer equals the memory top `RAM_END` (0x25F by default), so the low register reads 0x5F and the high register reads 0x02. The error flag is 0 and both lane enables are 0.
- R2: Operation code 1 pushes a data byte. Lane 0 carries the current pointer and lane 1 is unused, so the enables are 2'b01. The write strobe is 1, and the pointer drops by one at the clock edge.
- R3: Operation code 2 pops a data byte. Lane 0 carries the pointer plus one, the enables are 2'b01 and the write strobe is 0. The pointer rises by one at the edge.
- R4: Operation code 3 pushes a return address. Lane 0 carries the low byte's address, which is the current pointer. Lane 1 carries the high byte's address, which is the pointer minus one. The enables are 2'b11, the write strobe is 1, and the pointer drops by two.
- R5: Operation code 4 pops a return address. Lane 1 (high byte) carries the pointer plus one and lane 0 (low byte) carries the pointer plus two. The enables are 2'b11, the write strobe is 0, and the pointer rises by two.
- R6: Codes 0, 5, 6 and 7 are idle. Both enables are 0, both lane addresses read 0, the write strobe is 0, and the pointer is unchanged unless an I/O write is accepted.
- R7: The low register reads pointer bits [7:0]. The high register reads the remaining pointer bits, zero-extended to 8 bits. A write strobe on either register replaces that byte with the write data at the next edge. Data bits beyond the pointer width are dropped.
- R8: An I/O write issued in the same cycle as a stack operation (codes 1 to 4) is ignored. The pointer moves only as the operation requires.
- R9: A push of step S raises the error flag at its own clock edge when the pointer is below `FLOOR`+S (floor 0x60 by default). The push still moves the pointer. Pops never raise the flag, and the flag stays set across later operations.
- R10: An accepted I/O write to either register clears the error flag at the same edge.
- R11: Pointer arithmetic and lane addresses wrap modulo 2^`AW` (1024 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Stack operation code for this cycle |
| io_wr_lo_i | input | 1 | Write strobe for the low pointer register |
| io_wr_hi_i | input | 1 | Write strobe for the high pointer register |
| io_wdata_i | input | 8 | I/O write data |
| io_lo_o | output | 8 | Low pointer register read value |
| io_hi_o | output | 8 | High pointer register read value, zero-extended |
| lane0_addr_o | output | AW | Byte address, data byte or return-address low byte |
| lane1_addr_o | output | AW | Byte address, return-address high byte |
| lane_en_o | output | 2 | Lane enables, bit 0 for lane 0 |
| lane_wr_o | output | 1 | 1 for a store, 0 for a load |
| floor_err_o | output | 1 | Sticky flag for a push below the floor |

## Verification
The assertions assume the operation code is settled before each rising edge. They also assume reset is released between edges, so the first sampled cycle after reset sees the top-of-memory value. The stimulus drives `op_i` and the I/O strobes only on falling edges and releases reset midway between edges. Every code holds for exactly one cycle. The bench includes the reserved codes and also collides I/O writes with stack operations, so both the stacking rule and the write-blocking rule are exercised without breaking those assumptions.

// File: rtl/sp_pkg.sv
package sp_pkg;

   typedef enum logic [2:0] {
      OP_NONE      = 3'd0,
      OP_PUSH_BYTE = 3'd1,
      OP_POP_BYTE  = 3'd2,
      OP_PUSH_RET  = 3'd3,
      OP_POP_RET   = 3'd4
   } sp_op_e;

   localparam int OP_W     = 3;
   localparam int BYTE_W   = 8;
   localparam int LANE_CNT = 2;

   // true for the four codes that touch the stack
   function automatic logic op_moves(input logic [OP_W-1:0] code);
      return (code == OP_PUSH_BYTE) || (code == OP_POP_BYTE) ||
             (code == OP_PUSH_RET)  || (code == OP_POP_RET);
   endfunction

   function automatic logic op_is_push(input logic [OP_W-1:0] code);
      return (code == OP_PUSH_BYTE) || (code == OP_PUSH_RET);
   endfunction

endpackage

// File: rtl/sp_step_calc.sv
module sp_step_calc
   import sp_pkg::*;
#(
   parameter int AW    = 10,
   parameter int FLOOR = 'h60
)(
   input  logic [AW-1:0]       sp_i,
   input  logic [OP_W-1:0]     op_i,
   output logic [AW-1:0]       nxt_o,
   output logic [AW-1:0]       lane0_o,
   output logic [AW-1:0]       lane1_o,
   output logic [LANE_CNT-1:0] en_o,
   output logic                wr_o,
   output logic                move_o,
   output logic                under_o
);

   localparam logic [AW:0] LIM_ONE = (AW+1)'(FLOOR + 1);
   localparam logic [AW:0] LIM_TWO = (AW+1)'(FLOOR + 2);

   logic [AW-1:0] sp_m1, sp_m2, sp_p1, sp_p2;
   logic [AW:0]   sp_ext;

   assign sp_m1  = sp_i - AW'(1);
   assign sp_m2  = sp_i - AW'(2);
   assign sp_p1  = sp_i + AW'(1);
   assign sp_p2  = sp_i + AW'(2);
   assign sp_ext = {1'b0, sp_i};

   always_comb begin
      nxt_o   = sp_i;
      lane0_o = '0;
      lane1_o = '0;
      en_o    = '0;
      wr_o    = 1'b0;
      move_o  = 1'b0;
      under_o = 1'b0;
      case (op_i)
         OP_PUSH_BYTE: begin
            nxt_o   = sp_m1;
            lane0_o = sp_i;
            en_o    = 2'b01;
            wr_o    = 1'b1;
            move_o  = 1'b1;
            under_o = sp_ext < LIM_ONE;
         end
         OP_POP_BYTE: begin
            nxt_o   = sp_p1;
            lane0_o = sp_p1;
            en_o    = 2'b01;
            move_o  = 1'b1;
         end
         OP_PUSH_RET: begin
            nxt_o   = sp_m2;
            lane0_o = sp_i;
            lane1_o = sp_m1;
            en_o    = 2'b11;
            wr_o    = 1'b1;
            move_o  = 1'b1;
            under_o = sp_ext < LIM_TWO;
         end
         OP_POP_RET: begin
            nxt_o   = sp_p2;
            lane0_o = sp_p2;
            lane1_o = sp_p1;
            en_o    = 2'b11;
            move_o  = 1'b1;
         end
         default: ;
      endcase
   end

   // R4 / R5: the two lanes of a return address are always adjacent
   always_comb begin
      if (en_o == 2'b11) begin
         a_r4_lane_adjacent: assert ((wr_o && lane1_o == lane0_o - AW'(1)) ||
                                     (!wr_o && lane0_o == lane1_o + AW'(1)))
            else $error("return-address lanes not adjacent");
      end
   end

endmodule

// File: rtl/sp_byte_reg.sv
module sp_byte_reg #(
   parameter int          W   = 8,
   parameter logic [W-1:0] RST = '0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stk_ld_i,
   input  logic [W-1:0] stk_val_i,
   input  logic         io_ld_i,
   input  logic [W-1:0] io_val_i,
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o <= RST;
      else if (stk_ld_i) q_o <= stk_val_i;
      else if (io_ld_i)  q_o <= io_val_i;
   end

   // R8: a stack load always wins over a same-cycle I/O load
   a_r8_stack_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_ld_i && io_ld_i) |=> (q_o == $past(stk_val_i)));

endmodule

// File: rtl/sp_floor_guard.sv
module sp_floor_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic under_i,
   input  logic clear_i,
   output logic err_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_o <= 1'b0;
      else if (under_i) err_o <= 1'b1;
      else if (clear_i) err_o <= 1'b0;
   end

   a_r9_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
      under_i |=> err_o);

   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !clear_i) |=> err_o);

endmodule

// File: rtl/stack_pointer_unit.sv
module stack_pointer_unit
   import sp_pkg::*;
#(
   parameter int AW      = 10,
   parameter int RAM_END = 'h25F,
   parameter int FLOOR   = 'h60
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    op_i,
   input  logic          io_wr_lo_i,
   input  logic          io_wr_hi_i,
   input  logic [7:0]    io_wdata_i,
   output logic [7:0]    io_lo_o,
   output logic [7:0]    io_hi_o,
   output logic [AW-1:0] lane0_addr_o,
   output logic [AW-1:0] lane1_addr_o,
   output logic [1:0]    lane_en_o,
   output logic          lane_wr_o,
   output logic          floor_err_o
);

   localparam int            HI_W    = AW - BYTE_W;
   localparam logic [AW-1:0] RST_PTR = AW'(RAM_END);

   if (AW < BYTE_W || AW > 2*BYTE_W) begin : g_bad_aw
      $error("AW must lie between 8 and 16");
   end
   if (RAM_END >= (1 << AW) || FLOOR > RAM_END) begin : g_bad_range
      $error("RAM_END must fit AW and sit at or above FLOOR");
   end

   logic [AW-1:0]       sp_q;
   logic [AW-1:0]       sp_nxt;
   logic [LANE_CNT-1:0] en;
   logic                wr, move, under;
   logic                io_lo_ok, io_hi_ok;
   logic [BYTE_W-1:0]   lo_q;

   sp_step_calc #(.AW(AW), .FLOOR(FLOOR)) u_calc (
      .sp_i   (sp_q),
      .op_i   (op_i),
      .nxt_o  (sp_nxt),
      .lane0_o(lane0_addr_o),
      .lane1_o(lane1_addr_o),
      .en_o   (en),
      .wr_o   (wr),
      .move_o (move),
      .under_o(under)
   );

   assign lane_en_o = en;
   assign lane_wr_o = wr;

   // I/O writes only land in cycles with no stack traffic
   assign io_lo_ok = io_wr_lo_i && !move;
   assign io_hi_ok = io_wr_hi_i && !move;

   sp_byte_reg #(.W(BYTE_W), .RST(RST_PTR[BYTE_W-1:0])) u_lo (
      .clk      (clk),
      .rst_n    (rst_n),
      .stk_ld_i (move),
      .stk_val_i(sp_nxt[BYTE_W-1:0]),
      .io_ld_i  (io_lo_ok),
      .io_val_i (io_wdata_i),
      .q_o      (lo_q)
   );

   assign io_lo_o = lo_q;

   if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] hi_q;
      sp_byte_reg #(.W(HI_W), .RST(RST_PTR[AW-1:BYTE_W])) u_hi (
         .clk      (clk),
         .rst_n    (rst_n),
         .stk_ld_i (move),
         .stk_val_i(sp_nxt[AW-1:BYTE_W]),
         .io_ld_i  (io_hi_ok),
         .io_val_i (io_wdata_i[HI_W-1:0]),
         .q_o      (hi_q)
      );
      assign sp_q    = {hi_q, lo_q};
      assign io_hi_o = BYTE_W'(hi_q);
   end else begin : g_no_hi
      assign sp_q    = lo_q;
      assign io_hi_o = '0;
   end

   sp_floor_guard u_guard (
      .clk    (clk),
      .rst_n  (rst_n),
      .under_i(under),
      .clear_i(io_lo_ok || io_hi_ok),
      .err_o  (floor_err_o)
   );

   a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (sp_q == RST_PTR && !floor_err_o));

   a_r2_push_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_PUSH_BYTE) |=> (sp_q == $past(sp_q) - AW'(1)));

   a_r3_pop_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_POP_BYTE) |=> (sp_q == $past(sp_q) + AW'(1)));

   a_r4_push_ret: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_PUSH_RET) |=> (sp_q == $past(sp_q) - AW'(2)));

   a_r5_pop_ret: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_POP_RET) |=> (sp_q == $past(sp_q) + AW'(2)));

   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_moves(op_i) && !io_wr_lo_i && !io_wr_hi_i) |=> $stable(sp_q));

   a_r6_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      !op_moves(op_i) |-> (lane_en_o == 2'b00 && !lane_wr_o));

   a_r10_io_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_moves(op_i) && (io_wr_lo_i || io_wr_hi_i)) |=> !floor_err_o);

endmodule

// File: tb/stack_pointer_unit_test.sv
module stack_pointer_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 10;
   localparam int RAM_END    = 'h25F;
   localparam int FLOOR      = 'h60;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    op_i = '0;
   logic          io_wr_lo_i = 1'b0, io_wr_hi_i = 1'b0;
   logic [7:0]    io_wdata_i = '0;
   logic [7:0]    io_lo_o, io_hi_o;
   logic [AW-1:0] lane0_addr_o, lane1_addr_o;
   logic [1:0]    lane_en_o;
   logic          lane_wr_o, floor_err_o;

   stack_pointer_unit #(.AW(AW), .RAM_END(RAM_END), .FLOOR(FLOOR)) uut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      string         tag;
      logic [AW-1:0] a0, a1;
      logic [1:0]    en;
      logic          wr;
      logic [AW-1:0] sp_after;
      logic          err_after;
   } exp_t;

   exp_t          sb[$];
   int            total = 0, bad = 0;
   logic [AW-1:0] m_sp;
   logic          m_err;
   bit            done = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues what it must produce
   task automatic step(input logic [2:0] op, input logic wl, input logic wh,
                       input logic [7:0] wd, input string tag);
      exp_t e;
      logic [AW-1:0] sp;
      int st;
      @(negedge clk);
      op_i = op; io_wr_lo_i = wl; io_wr_hi_i = wh; io_wdata_i = wd;
      sp = m_sp; st = 0;
      e.tag = tag; e.a0 = '0; e.a1 = '0; e.en = 2'b00; e.wr = 1'b0;
      case (op)
         3'd1: begin e.a0 = sp; e.en = 2'b01; e.wr = 1'b1; m_sp = sp - 1'b1; st = 1; end
         3'd2: begin e.a0 = sp + 1'b1; e.en = 2'b01; m_sp = sp + 1'b1; end
         3'd3: begin e.a0 = sp; e.a1 = sp - 1'b1; e.en = 2'b11; e.wr = 1'b1;
                     m_sp = sp - 2'd2; st = 2; end
         3'd4: begin e.a0 = sp + 2'd2; e.a1 = sp + 1'b1; e.en = 2'b11; m_sp = sp + 2'd2; end
         default: begin
            if (wl) m_sp[7:0] = wd;
            if (wh) m_sp[AW-1:8] = wd[AW-9:0];
            if (wl || wh) m_err = 1'b0;
         end
      endcase
      if (st != 0 && int'(sp) < FLOOR + st) m_err = 1'b1;
      e.sp_after = m_sp; e.err_after = m_err;
      sb.push_back(e);
   endtask

   // monitor: lanes mid-cycle, register state after the edge
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() != 0) begin
            e = sb.pop_front();
            chk(e.tag, "lane0", int'(lane0_addr_o), int'(e.a0));
            chk(e.tag, "lane1", int'(lane1_addr_o), int'(e.a1));
            chk(e.tag, "lane_en", int'(lane_en_o), int'(e.en));
            chk(e.tag, "lane_wr", int'(lane_wr_o), int'(e.wr));
            @(posedge clk);
            #2;
            chk(e.tag, "io_lo", int'(io_lo_o), int'(e.sp_after[7:0]));
            chk(e.tag, "io_hi", int'(io_hi_o), int'(e.sp_after[AW-1:8]));
            chk(e.tag, "floor_err", int'(floor_err_o), int'(e.err_after));
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_sp = AW'(RAM_END); m_err = 1'b0;
      #(CLK_PERIOD * 3 + 2);
      rst_n = 1'b1;
      @(posedge clk); #2;
      // R1 reset state
      chk("R1", "io_lo", int'(io_lo_o), 'h5F);
      chk("R1", "io_hi", int'(io_hi_o), 'h02);
      chk("R1", "floor_err", int'(floor_err_o), 0);
      chk("R1", "lane_en", int'(lane_en_o), 0);

      step(3'd1, 0, 0, 8'h00, "R2");
      step(3'd1, 0, 0, 8'h00, "R2");
      step(3'd2, 0, 0, 8'h00, "R3");
      step(3'd3, 0, 0, 8'h00, "R4");
      step(3'd3, 0, 0, 8'h00, "R4");
      step(3'd4, 0, 0, 8'h00, "R5");
      step(3'd4, 0, 0, 8'h00, "R5");
      step(3'd0, 0, 0, 8'h00, "R6");
      step(3'd5, 0, 0, 8'h00, "R6");
      step(3'd6, 0, 0, 8'h00, "R6");
      step(3'd7, 0, 0, 8'h00, "R6");
      step(3'd0, 1, 0, 8'h61, "R7");
      step(3'd0, 0, 1, 8'hFF, "R7");   // only two high bits exist
      step(3'd6, 0, 1, 8'h00, "R7");   // reserved code still lets I/O in
      step(3'd1, 0, 0, 8'h00, "R9");   // 0x61 -> 0x60, no flag
      step(3'd1, 0, 0, 8'h00, "R9");   // 0x60 -> 0x5F, flag
      step(3'd2, 0, 0, 8'h00, "R9");   // pop keeps flag
      step(3'd1, 1, 0, 8'hAA, "R8");   // I/O write blocked
      step(3'd4, 0, 1, 8'h01, "R8");
      step(3'd0, 1, 0, 8'h62, "R10");
      step(3'd3, 0, 0, 8'h00, "R9");   // 0x62 -> 0x60, no flag
      step(3'd0, 1, 0, 8'h61, "R10");
      step(3'd3, 0, 0, 8'h00, "R9");   // 0x61 -> 0x5F, flag
      step(3'd0, 1, 1, 8'h00, "R10");
      step(3'd1, 0, 0, 8'h00, "R11");  // 0x000 -> 0x3FF
      step(3'd4, 0, 0, 8'h00, "R11");  // 0x3FF -> 0x001
      step(3'd0, 0, 1, 8'h03, "R10");
      step(3'd0, 1, 0, 8'hFF, "R11");
      step(3'd2, 0, 0, 8'h00, "R11");  // 0x3FF -> 0x000
      step(3'd3, 0, 0, 8'h00, "R11");  // 0x000 -> 0x3FE
      for (int i = 0; i < 4; i++) step(3'd3, 0, 0, 8'h00, "R4");
      for (int i = 0; i < 4; i++) step(3'd4, 0, 0, 8'h00, "R5");

      @(negedge clk);
      op_i = 3'd0; io_wr_lo_i = 1'b0; io_wr_hi_i = 1'b0;
      repeat (3) @(posedge clk);
      #3;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule